// File: doc/BRIEF.md
# Auto-Ranging Master Clock Prescaler

This block turns a master clock of unknown frequency into a steady 256 kHz sequencing strobe. The master clock is known to run at one of seven rates: 256, 512, 1536, 1544, 2048, 2560 or 4096 kHz. The block works out which rate it has by counting master clock cycles between rising edges of the 8 kHz transmit frame sync. These counts are nominally 32, 64, 192, 193, 256, 320 and 512. Once two periods in a row agree on a rate, the block locks. It then emits 32 evenly spaced enable pulses per frame, spaced by the count divided by 32. For the 1544 kHz case the count is 193, so the pulses use a spacing of six and the odd cycle at the end of each frame is left idle.

The whole block runs in the master clock domain and samples the frame sync as a level. Only rising edges of the frame sync are used, so short and long frame sync formats behave the same. The handling does not depend on the PCM transfer mode. The lock controller has four states:

- `ST_IDLE`: no frame sync edge seen yet.
- `ST_MEASURE`: a reference edge exists but there is no candidate rate.
- `ST_CONFIRM`: one period has been classified and the block waits for a second matching period.
- `ST_LOCKED`: the strobe is running.

The transitions are:

- IDLE→MEASURE on the first edge.
- MEASURE→CONFIRM on an edge with a valid count.
- CONFIRM→LOCKED on an edge whose class matches the candidate.
- CONFIRM→CONFIRM, with the candidate replaced, on an edge with a different valid class.
- LOCKED→CONFIRM on an edge with a different valid class.
- CONFIRM or LOCKED→MEASURE on an out-of-range count or a frame sync timeout.
- Every other case holds the current state.

Top module: `mclk_autorange_prescaler`

## Requirements
- R1: After reset, `locked` and `seq_en` are 0 and `rate_sel` is 7.
- R2: The count between consecutive frame sync rising edges is classified with codes 0..6 in ascending rate order: 0=32, 1=64, 2=192, 3=193, 4=256, 5=320, 6=512. Each class accepts its nominal count ±2. The overlapping pair is split at the midpoint, so counts 190–192 give code 2 and counts 193–195 give code 3. Any other count is invalid.
- R3: `locked` rises one register stage after the frame sync edge that ends the second consecutive period with the same class. It never rises except at a frame sync rising edge.
- R4: While locked, `rate_sel` shows the locked code and stays stable. While not locked, it reads 7.
- R5: While locked, `seq_en` is high at the commit edge and then every D cycles after it, where D is the nominal count divided by 32 (1, 2, 6, 6, 8, 10, 16). There are at most 32 pulses per frame, after which `seq_en` stays low until the next edge. It is never high while unlocked.
- R6: With a 193-cycle frame, 32 pulses spaced 6 apart are issued, and the 193rd cycle carries no pulse.
- R7: An edge that ends an invalid count drops `locked`, `seq_en` and `rate_sel` at that edge.
- R8: If 515 cycles pass after a frame sync rising edge with no new edge, lock is dropped at that 515th cycle. At 514 cycles the block is still locked.
- R9: A different valid class while locked unlocks the block. It relocks on the new class after one more matching period, and the pulse train restarts at that edge.
- R10: Every frame sync rising edge that keeps the block locked re-anchors the pulse train to that edge.
- R11: The frame sync high width has no effect. Only the rising edge matters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, one of the seven supported rates |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | 8 kHz transmit frame sync, sampled as a level |
| seq_en | output | 1 | 256 kHz sequencing enable, one master clock cycle wide |
| locked | output | 1 | Rate detected and strobe running |
| rate_sel | output | 3 | Detected rate code 0..6, or 7 when not locked |

## Verification
The bench builds the block with its default parameters: a tolerance of 2 counts and 32 pulses per frame. With these values the 192/193 overlap is split at the midpoint, so the bench can drive frames of 190, 192, 193, 195 and 196 cycles and reach both sides of that split and the invalid count just beyond it. The timeout limit works out to 515 cycles, so the 514/515 cycle boundary after the last edge is reachable within a short run. The window edges at 29/30, 510 and 514 counts are driven as well.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

    localparam int unsigned NUM_RATES = 7;
    localparam int unsigned SEL_W     = 3;
    localparam logic [SEL_W-1:0] SEL_NONE = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_CONFIRM,
        ST_LOCKED
    } lock_state_t;

    // Nominal master clock cycles per frame, ascending.
    function automatic int unsigned rate_ratio(input int unsigned idx);
        case (idx)
            0:       return 32;
            1:       return 64;
            2:       return 192;
            3:       return 193;
            4:       return 256;
            5:       return 320;
            default: return 512;
        endcase
    endfunction

    // Lower bound of the acceptance window; neighbours closer than two
    // tolerances share the gap at the midpoint.
    function automatic int unsigned win_lo(input int unsigned idx, input int unsigned tol);
        if (idx == 0)
            return rate_ratio(0) - tol;
        if (rate_ratio(idx) - rate_ratio(idx - 1) <= 2 * tol)
            return (rate_ratio(idx - 1) + rate_ratio(idx) - 1) / 2 + 1;
        return rate_ratio(idx) - tol;
    endfunction

    function automatic int unsigned win_hi(input int unsigned idx, input int unsigned tol);
        if (idx == NUM_RATES - 1)
            return rate_ratio(idx) + tol;
        if (rate_ratio(idx + 1) - rate_ratio(idx) <= 2 * tol)
            return (rate_ratio(idx) + rate_ratio(idx + 1) - 1) / 2;
        return rate_ratio(idx) + tol;
    endfunction

endpackage

// File: rtl/mcp_period_meter.sv
module mcp_period_meter #(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned LIMIT = 515
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs,
    output logic             rise,
    output logic             timeout,
    output logic [CNT_W-1:0] period
);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    logic             fs_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_d  <= 1'b0;
            cnt_q <= '0;
        end else begin
            fs_d <= fs;
            if (rise)
                cnt_q <= CNT_W'(1);
            else if (cnt_q < LIMIT_V)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign rise    = fs & ~fs_d;
    assign timeout = (cnt_q == LIMIT_V) & ~rise;
    assign period  = cnt_q;

endmodule

// File: rtl/mcp_rate_classifier.sv
module mcp_rate_classifier #(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned TOL   = 2
) (
    input  logic                         [CNT_W-1:0] period,
    output logic                                     hit,
    output logic [mcp_pkg::SEL_W-1:0]                code
);
    localparam int unsigned N = mcp_pkg::NUM_RATES;

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_win
        localparam logic [CNT_W-1:0] LO_V = CNT_W'(mcp_pkg::win_lo(g, TOL));
        localparam logic [CNT_W-1:0] HI_V = CNT_W'(mcp_pkg::win_hi(g, TOL));
        assign match[g] = (period >= LO_V) && (period <= HI_V);
    end

    always_comb begin
        hit  = 1'b0;
        code = mcp_pkg::SEL_NONE;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit  = 1'b1;
                code = mcp_pkg::SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/mcp_lock_fsm.sv
module mcp_lock_fsm
    import mcp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             timeout,
    input  logic             hit,
    input  logic [SEL_W-1:0] code,
    output logic             run,
    output logic             commit,
    output logic             locked,
    output logic [SEL_W-1:0] rate_sel
);
    lock_state_t      st_q, st_n;
    logic [SEL_W-1:0] cand_q, cand_n;
    logic [SEL_W-1:0] act_q, act_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cand_q <= SEL_NONE;
            act_q  <= SEL_NONE;
        end else begin
            st_q   <= st_n;
            cand_q <= cand_n;
            act_q  <= act_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        cand_n = cand_q;
        act_n  = act_q;
        unique case (st_q)
            ST_IDLE: begin
                if (rise) st_n = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (rise && hit) begin
                    st_n   = ST_CONFIRM;
                    cand_n = code;
                end
            end
            ST_CONFIRM: begin
                if (rise) begin
                    if (!hit) begin
                        st_n = ST_MEASURE;
                    end else if (code == cand_q) begin
                        st_n  = ST_LOCKED;
                        act_n = code;
                    end else begin
                        cand_n = code;
                    end
                end else if (timeout) begin
                    st_n = ST_MEASURE;
                end
            end
            ST_LOCKED: begin
                if (rise) begin
                    if (!hit) begin
                        st_n = ST_MEASURE;
                    end else if (code != act_q) begin
                        st_n   = ST_CONFIRM;
                        cand_n = code;
                    end
                end else if (timeout) begin
                    st_n = ST_MEASURE;
                end
            end
        endcase
    end

    assign run    = (st_n == ST_LOCKED);
    assign commit = rise && run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            rate_sel <= SEL_NONE;
        end else begin
            locked   <= run;
            rate_sel <= run ? act_n : SEL_NONE;
        end
    end

endmodule

// File: rtl/mcp_enable_gen.sv
module mcp_enable_gen #(
    parameter int unsigned SLOTS = 32,
    parameter int unsigned DIV_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      commit,
    input  logic [mcp_pkg::SEL_W-1:0] code,
    output logic                      en
);
    localparam int unsigned PC_W = $clog2(SLOTS + 1);
    localparam logic [PC_W-1:0] SLOTS_V = PC_W'(SLOTS);

    logic [DIV_W-1:0] div_q, reload_q, reload_n;
    logic [PC_W-1:0]  pulses_q;

    always_comb begin
        reload_n = DIV_W'(mcp_pkg::rate_ratio(32'(code)) / SLOTS - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            en       <= 1'b0;
            div_q    <= '0;
            reload_q <= '0;
            pulses_q <= '0;
        end else if (commit) begin
            en       <= 1'b1;
            div_q    <= reload_n;
            reload_q <= reload_n;
            pulses_q <= PC_W'(1);
        end else if (pulses_q < SLOTS_V) begin
            if (div_q == '0) begin
                en       <= 1'b1;
                div_q    <= reload_q;
                pulses_q <= pulses_q + PC_W'(1);
            end else begin
                en    <= 1'b0;
                div_q <= div_q - DIV_W'(1);
            end
        end else begin
            en <= 1'b0;
        end
    end

endmodule

// File: rtl/mclk_autorange_prescaler.sv
module mclk_autorange_prescaler #(
    parameter int unsigned TOL   = 2,
    parameter int unsigned SLOTS = 32
) (
    input  logic                      mclk,
    input  logic                      rst_n,
    input  logic                      frame_sync,
    output logic                      seq_en,
    output logic                      locked,
    output logic [mcp_pkg::SEL_W-1:0] rate_sel
);
    localparam int unsigned MAX_RATIO = mcp_pkg::rate_ratio(mcp_pkg::NUM_RATES - 1);
    localparam int unsigned LIMIT     = MAX_RATIO + TOL + 1;
    localparam int unsigned CNT_W     = $clog2(LIMIT + 1);
    localparam int unsigned DIV_RAW   = $clog2(MAX_RATIO / SLOTS);
    localparam int unsigned DIV_W     = (DIV_RAW > 0) ? DIV_RAW : 1;

    logic                      rise, timeout, hit, run, commit;
    logic [CNT_W-1:0]          period;
    logic [mcp_pkg::SEL_W-1:0] code;

    mcp_period_meter #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_meter (
        .clk(mclk), .rst_n(rst_n), .fs(frame_sync),
        .rise(rise), .timeout(timeout), .period(period)
    );

    mcp_rate_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
        .period(period), .hit(hit), .code(code)
    );

    mcp_lock_fsm u_fsm (
        .clk(mclk), .rst_n(rst_n), .rise(rise), .timeout(timeout),
        .hit(hit), .code(code), .run(run), .commit(commit),
        .locked(locked), .rate_sel(rate_sel)
    );

    mcp_enable_gen #(.SLOTS(SLOTS), .DIV_W(DIV_W)) u_div (
        .clk(mclk), .rst_n(rst_n), .run(run), .commit(commit),
        .code(code), .en(seq_en)
    );

endmodule

// File: rtl/mcp_checker.sv
module mcp_checker #(
    parameter int unsigned SLOTS = 32
) (
    input logic                      mclk,
    input logic                      rst_n,
    input logic                      frame_sync,
    input logic                      seq_en,
    input logic                      locked,
    input logic [mcp_pkg::SEL_W-1:0] rate_sel
);
    localparam int unsigned EC_W = $clog2(SLOTS + 2);
    localparam logic [EC_W-1:0] SLOTS_V = EC_W'(SLOTS);

    logic            fs_seen, edge_prev;
    logic [EC_W-1:0] en_cnt;

    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            fs_seen   <= 1'b0;
            edge_prev <= 1'b0;
            en_cnt    <= '0;
        end else begin
            fs_seen   <= frame_sync;
            edge_prev <= frame_sync & ~fs_seen;
            if (edge_prev)
                en_cnt <= EC_W'(seq_en);
            else if (seq_en && en_cnt <= SLOTS_V)
                en_cnt <= en_cnt + EC_W'(1);
        end
    end

    p_en_needs_lock_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        seq_en |-> locked);

    p_frame_enables_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        en_cnt <= SLOTS_V);

    p_rate_none_unlocked_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        !locked |-> (rate_sel == mcp_pkg::SEL_NONE));

    p_rate_stable_locked_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(rate_sel));

    p_lock_after_edge_r3: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(locked) |-> $past(frame_sync));

endmodule

bind mclk_autorange_prescaler mcp_checker #(.SLOTS(SLOTS)) u_chk (
    .mclk(mclk), .rst_n(rst_n), .frame_sync(frame_sync),
    .seq_en(seq_en), .locked(locked), .rate_sel(rate_sel)
);

// File: tb/mclk_autorange_prescaler_bench.sv
`timescale 1ns/1ps
module mclk_autorange_prescaler_bench;

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       seq_en, locked;
    logic [2:0] rate_sel;

    always #2.5 mclk = ~mclk;

    mclk_autorange_prescaler u_mclk_autorange_prescaler (
        .mclk(mclk), .rst_n(rst_n), .frame_sync(frame_sync),
        .seq_en(seq_en), .locked(locked), .rate_sel(rate_sel)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    int nominal [7] = '{32, 64, 192, 193, 256, 320, 512};
    int spacing [7] = '{1, 2, 6, 6, 8, 10, 16};
    localparam int TIMEOUT_CYC = 515;

    // behavioural reference state
    int cyc = 0, last_edge = 0, mode = 0, cand = -1, act = -1, anchor = 0;
    int en_seen = 0;
    bit prev_fs = 0;

    function automatic int classify(input int k);
        int best = -1, bestd = 3;
        for (int i = 0; i < 7; i++) begin
            int d = (k > nominal[i]) ? k - nominal[i] : nominal[i] - k;
            if (d <= 2 && d < bestd) begin best = i; bestd = d; end
        end
        return best;
    endfunction

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act_v, exp_v, cyc);
        end
    endtask

    task automatic step(input bit fsv);
        bit rise;
        int c, p;
        bit e_lock, e_en;
        int e_rate;
        @(negedge mclk);
        frame_sync = fsv;
        @(posedge mclk);
        cyc++;
        rise = fsv && !prev_fs;
        prev_fs = fsv;
        if (rise) begin
            c = classify(cyc - last_edge);
            last_edge = cyc;
            case (mode)
                0: mode = 1;
                1: if (c >= 0) begin mode = 2; cand = c; end
                2: if (c < 0) mode = 1;
                   else if (c == cand) begin mode = 3; act = c; anchor = cyc; end
                   else cand = c;
                default: if (c < 0) mode = 1;
                   else if (c != act) begin mode = 2; cand = c; end
                   else anchor = cyc;
            endcase
        end else if (mode >= 2 && cyc - last_edge >= TIMEOUT_CYC) begin
            mode = 1;
        end
        e_lock = (mode == 3);
        e_rate = e_lock ? act : 7;
        e_en = 1'b0;
        if (e_lock) begin
            p = cyc - anchor;
            e_en = (p % spacing[act] == 0) && (p / spacing[act] < 32);
        end
        #2;
        if (seq_en) en_seen++;
        chk(locked == e_lock, {cur_req, " R3"}, locked, e_lock, "locked");
        chk(int'(rate_sel) == e_rate, {cur_req, " R4"}, rate_sel, e_rate, "rate_sel");
        chk(seq_en == e_en, {cur_req, " R5"}, seq_en, e_en, "seq_en");
    endtask

    task automatic frames(input int n, input int period, input int width);
        for (int f = 0; f < n; f++)
            for (int j = 0; j < period; j++)
                step(j < width);
    endtask

    task automatic expect_state(input string req, input bit l, input int r);
        chk(locked == l, req, locked, l, "locked");
        chk(int'(rate_sel) == r, req, rate_sel, r, "rate_sel");
    endtask

    initial begin
        repeat (4) @(posedge mclk);
        #2;
        // R1 reset state
        chk(locked == 1'b0, "R1", locked, 0, "locked");
        chk(seq_en == 1'b0, "R1", seq_en, 0, "seq_en");
        chk(rate_sel == 3'd7, "R1", rate_sel, 7, "rate_sel");
        @(negedge mclk);
        rst_n = 1'b1;

        cur_req = "R3";
        frames(2, 32, 1);
        expect_state("R3", 0, 7);
        frames(2, 32, 1);
        expect_state("R2", 1, 0);

        cur_req = "R11";
        frames(3, 64, 5);
        expect_state("R11", 1, 1);

        cur_req = "R9";
        frames(3, 193, 2);
        expect_state("R9", 1, 3);
        frames(3, 192, 1);
        expect_state("R9", 1, 2);
        cur_req = "R2";
        frames(3, 190, 1);
        expect_state("R2", 1, 2);
        frames(3, 195, 1);
        expect_state("R2", 1, 3);
        frames(3, 194, 7);
        expect_state("R10", 1, 3);

        cur_req = "R7";
        frames(2, 196, 1);
        expect_state("R7", 0, 7);
        frames(3, 256, 1);
        expect_state("R2", 1, 4);
        cur_req = "R5";
        en_seen = 0;
        frames(1, 256, 1);
        chk(en_seen == 32, "R5", en_seen, 32, "pulses per frame");

        cur_req = "R6";
        frames(3, 193, 1);
        expect_state("R6", 1, 3);
        en_seen = 0;
        frames(1, 193, 1);
        chk(en_seen == 32, "R6", en_seen, 32, "pulses per 193 frame");

        cur_req = "R2";
        frames(3, 320, 3);
        expect_state("R2", 1, 5);
        frames(3, 512, 1);
        expect_state("R2", 1, 6);
        frames(2, 514, 1);
        expect_state("R2", 1, 6);
        frames(2, 510, 1);
        cur_req = "R8";
        repeat (4) step(1'b0);
        expect_state("R8", 1, 6);
        repeat (2) step(1'b0);
        expect_state("R8", 0, 7);
        repeat (20) step(1'b0);

        cur_req = "R2";
        frames(3, 30, 1);
        expect_state("R2", 1, 0);
        cur_req = "R7";
        frames(2, 29, 1);
        expect_state("R7", 0, 7);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule